// File: doc/BRIEF.md
# Time-Slotted Bufferless Mesh Switch

This block is the switch of one tile in a two-dimensional mesh network on chip. It has five ports, one per compass neighbour and one toward the tile's own network interface. A slot counter steps through a fixed period of `PERIOD` cycles. A schedule table held in registers gives, for every slot and every output, whether that output is reserved and which input feeds it. All paths are decided ahead of time by that table. Nothing is decided from flit contents at run time.

The switch stores no flits. A flit on a scheduled input appears on its output in the same cycle through a combinational crossbar. When an output has no reservation in the current slot, the local network interface may send a best-effort flit toward that neighbour direction. The flit is accepted only when that direction is free in the current slot. If it is not accepted, the interface keeps it and offers it again later. The table can be written only while the switch is disabled. Enabling the switch starts the period at slot 0.

Top module: `tdma_mesh_router`

## Requirements
- R1: After reset every table entry is unreserved, all `out_valid` bits and all `out_data` bits are 0, and `be_ready` is 0.
- R2: While `enable` is low the slot is held at 0. In the first enabled cycle the slot is 0. It then advances by one each enabled cycle and wraps from `PERIOD-1` to 0.
- R3: Port codes are 0 north, 1 east, 2 south, 3 west, 4 local. When output o is reserved in the current slot with a select code from 0 to 4, `out_valid[o]` and that output's 128-bit data equal the valid bit and data of the selected input in the same cycle.
- R4: A reserved output drives `out_valid` low when its selected input is not valid, or when its select code is 5, 6 or 7. This holds even if a best-effort flit is aimed at that output.
- R5: When the entry for neighbour output `be_dir` (0 to 3) is unreserved in the current slot and `be_valid` is high, that output carries `be_data` with valid high and `be_ready` is 1.
- R6: `be_ready` is 0, and no output carries the best-effort flit, when the entry for direction `be_dir` is reserved in the current slot or when `be_dir` is 4 to 7.
- R7: While `enable` is low every output is invalid and `be_ready` is 0.
- R8: A write on the configuration port with `cfg_we` high and `enable` low sets entry (`cfg_slot`, `cfg_port`) to {`cfg_valid`, `cfg_sel`} at the clock edge. A write while `enable` is high changes nothing.
- R9: Whenever `out_valid[o]` is 0, the 128 data bits of output o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the slot counter and the crossbar |
| cfg_we | input | 1 | Table write strobe (used only while disabled) |
| cfg_slot | input | SLOT_W | Slot index to write |
| cfg_port | input | 3 | Output port code to write |
| cfg_valid | input | 1 | Reservation bit to write |
| cfg_sel | input | 3 | Input select code to write |
| in_valid | input | 5 | Input valid bits, bit index = port code |
| in_data | input | 5*DATA_W | Input data, port p at bits p*DATA_W upward |
| be_valid | input | 1 | Local best-effort flit offered |
| be_dir | input | 3 | Output direction code for the best-effort flit |
| be_data | input | DATA_W | Best-effort flit data |
| be_ready | output | 1 | Best-effort flit accepted this cycle |
| out_valid | output | 5 | Output valid bits, bit index = port code |
| out_data | output | 5*DATA_W | Output data, same packing as inputs |

## Verification
The hardest case to reach from the ports is a best-effort flit aimed at an output in a slot where that output is reserved but its scheduled input is idle. The output must stay quiet rather than take the free-looking cycle. The test schedule reserves some outputs with dead select codes (5 to 7) and leaves others empty. Random input valids run at about half density, and best-effort directions are drawn over all eight codes. Over several periods, every pairing of reserved/free with busy/idle therefore comes up in every slot. Table writes attempted while enabled are mixed into the random run and must leave the traffic unchanged.

// File: rtl/tdma_router_pkg.sv
package tdma_router_pkg;
  localparam int NUM_PORTS = 5;
  localparam int SEL_W     = 3;

  typedef enum logic [SEL_W-1:0] {
    PORT_N = 3'd0,
    PORT_E = 3'd1,
    PORT_S = 3'd2,
    PORT_W = 3'd3,
    PORT_L = 3'd4
  } port_e;

  typedef struct packed {
    logic             vld;
    logic [SEL_W-1:0] sel;
  } route_t;
endpackage

// File: rtl/tdma_slot_counter.sv
module tdma_slot_counter #(
  parameter int PERIOD = 8,
  localparam int SLOT_W = $clog2(PERIOD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  output logic [SLOT_W-1:0] slot
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(PERIOD - 1);

  logic [SLOT_W-1:0] slot_q, slot_d;

  always_comb begin
    slot_d = slot_q;
    if (!run)              slot_d = '0;
    else if (slot_q == LAST) slot_d = '0;
    else                   slot_d = slot_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  assign slot = slot_q;
endmodule

// File: rtl/tdma_sched_table.sv
module tdma_sched_table
  import tdma_router_pkg::*;
#(
  parameter int PERIOD = 8,
  localparam int SLOT_W = $clog2(PERIOD)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [SLOT_W-1:0]            wr_slot,
  input  logic [SEL_W-1:0]             wr_port,
  input  route_t                       wr_route,
  input  logic [SLOT_W-1:0]            rd_slot,
  output route_t [NUM_PORTS-1:0]       rd_routes
);
  route_t [NUM_PORTS-1:0] tbl_q [PERIOD];
  route_t [NUM_PORTS-1:0] tbl_d [PERIOD];

  always_comb begin
    for (int s = 0; s < PERIOD; s++) begin
      tbl_d[s] = tbl_q[s];
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (wr_en && (int'(wr_slot) == s) && (int'(wr_port) == p))
          tbl_d[s][p] = wr_route;
      end
    end
  end

  for (genvar s = 0; s < PERIOD; s++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     tbl_q[s] <= '0;
      else if (wr_en) tbl_q[s] <= tbl_d[s];
    end
  end

  always_comb begin
    rd_routes = '0;
    for (int s = 0; s < PERIOD; s++)
      if (int'(rd_slot) == s) rd_routes = tbl_q[s];
  end
endmodule

// File: rtl/tdma_crossbar.sv
module tdma_crossbar
  import tdma_router_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic                          active,
  input  route_t [NUM_PORTS-1:0]        routes,
  input  logic [NUM_PORTS-1:0]          in_valid,
  input  logic [NUM_PORTS*DATA_W-1:0]   in_data,
  input  logic                          be_valid,
  input  logic [SEL_W-1:0]              be_dir,
  input  logic [DATA_W-1:0]             be_data,
  output logic                          be_ready,
  output logic [NUM_PORTS-1:0]          out_valid,
  output logic [NUM_PORTS*DATA_W-1:0]   out_data
);
  localparam int NUM_NBR = NUM_PORTS - 1;

  always_comb begin
    out_valid = '0;
    out_data  = '0;
    be_ready  = 1'b0;
    for (int o = 0; o < NUM_PORTS; o++) begin
      if (active) begin
        if (routes[o].vld) begin
          for (int i = 0; i < NUM_PORTS; i++) begin
            if ((int'(routes[o].sel) == i) && in_valid[i]) begin
              out_valid[o] = 1'b1;
              out_data[o*DATA_W +: DATA_W] = in_data[i*DATA_W +: DATA_W];
            end
          end
        end else if (o < NUM_NBR && be_valid && int'(be_dir) == o) begin
          out_valid[o] = 1'b1;
          out_data[o*DATA_W +: DATA_W] = be_data;
          be_ready = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tdma_mesh_router.sv
module tdma_mesh_router
  import tdma_router_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int PERIOD = 8,
  localparam int SLOT_W = $clog2(PERIOD)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          enable,
  input  logic                          cfg_we,
  input  logic [SLOT_W-1:0]             cfg_slot,
  input  logic [2:0]                    cfg_port,
  input  logic                          cfg_valid,
  input  logic [2:0]                    cfg_sel,
  input  logic [4:0]                    in_valid,
  input  logic [5*DATA_W-1:0]           in_data,
  input  logic                          be_valid,
  input  logic [2:0]                    be_dir,
  input  logic [DATA_W-1:0]             be_data,
  output logic                          be_ready,
  output logic [4:0]                    out_valid,
  output logic [5*DATA_W-1:0]           out_data
);
  logic                   tbl_wr;
  route_t                 tbl_wdat;
  logic [SLOT_W-1:0]      slot_q;
  route_t [NUM_PORTS-1:0] cur_routes;

  assign tbl_wr   = cfg_we & ~enable;
  assign tbl_wdat = '{vld: cfg_valid, sel: cfg_sel};

  tdma_slot_counter #(.PERIOD(PERIOD)) u_slot (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (enable),
    .slot (slot_q)
  );

  tdma_sched_table #(.PERIOD(PERIOD)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (tbl_wr),
    .wr_slot  (cfg_slot),
    .wr_port  (cfg_port),
    .wr_route (tbl_wdat),
    .rd_slot  (slot_q),
    .rd_routes(cur_routes)
  );

  tdma_crossbar #(.DATA_W(DATA_W)) u_xbar (
    .active   (enable),
    .routes   (cur_routes),
    .in_valid (in_valid),
    .in_data  (in_data),
    .be_valid (be_valid),
    .be_dir   (be_dir),
    .be_data  (be_data),
    .be_ready (be_ready),
    .out_valid(out_valid),
    .out_data (out_data)
  );
endmodule

// File: rtl/tdma_router_chk.sv
module tdma_router_chk
  import tdma_router_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int PERIOD = 8,
  localparam int SLOT_W = $clog2(PERIOD)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        enable,
  input logic [SLOT_W-1:0]           slot,
  input route_t [NUM_PORTS-1:0]      routes,
  input logic [2:0]                  be_dir,
  input logic [DATA_W-1:0]           be_data,
  input logic                        be_ready,
  input logic [4:0]                  out_valid,
  input logic [5*DATA_W-1:0]         out_data
);
  a_r2_slot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && slot == SLOT_W'(PERIOD-1)) |=> slot == '0);

  a_r2_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && slot != SLOT_W'(PERIOD-1)) |=> slot == $past(slot) + 1'b1);

  a_r2_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> slot == '0);

  a_r7_quiet_out: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (out_valid == '0 && !be_ready));

  a_r6_be_nbr_only: assert property (@(posedge clk) disable iff (!rst_n)
    be_ready |-> be_dir < 3'd4);

  a_r6_be_free_slot: assert property (@(posedge clk) disable iff (!rst_n)
    be_ready |-> !routes[be_dir[1:0]].vld);

  a_r5_be_carried: assert property (@(posedge clk) disable iff (!rst_n)
    be_ready |-> (out_valid[be_dir[1:0]] &&
                  out_data[be_dir[1:0]*DATA_W +: DATA_W] == be_data));
endmodule

bind tdma_mesh_router tdma_router_chk #(.DATA_W(DATA_W), .PERIOD(PERIOD)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .slot     (slot_q),
  .routes   (cur_routes),
  .be_dir   (be_dir),
  .be_data  (be_data),
  .be_ready (be_ready),
  .out_valid(out_valid),
  .out_data (out_data)
);

// File: tb/tdma_mesh_router_tb_top.sv
module tdma_mesh_router_tb_top;
  localparam int DW = 128;
  localparam int P  = 8;
  localparam int SW = $clog2(P);

  logic            clk = 1'b0;
  logic            rst_n;
  logic            enable;
  logic            cfg_we;
  logic [SW-1:0]   cfg_slot;
  logic [2:0]      cfg_port;
  logic            cfg_valid;
  logic [2:0]      cfg_sel;
  logic [4:0]      in_valid;
  logic [5*DW-1:0] in_data;
  logic            be_valid;
  logic [2:0]      be_dir;
  logic [DW-1:0]   be_data;
  logic            be_ready;
  logic [4:0]      out_valid;
  logic [5*DW-1:0] out_data;

  int n_chk  = 0;
  int n_fail = 0;
  int bslot  = 0;
  bit         m_vld [P][5];
  logic [2:0] m_sel [P][5];

  always #5 clk = ~clk;

  tdma_mesh_router #(.DATA_W(DW), .PERIOD(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_port(cfg_port),
    .cfg_valid(cfg_valid), .cfg_sel(cfg_sel),
    .in_valid(in_valid), .in_data(in_data),
    .be_valid(be_valid), .be_dir(be_dir), .be_data(be_data),
    .be_ready(be_ready), .out_valid(out_valid), .out_data(out_data)
  );

  task automatic check(string req, logic [DW:0] act, logic [DW:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rnd_word();
    logic [DW-1:0] w;
    for (int k = 0; k < DW/32; k++) w[k*32 +: 32] = $urandom;
    return w;
  endfunction

  // expected {valid, data} of output o from the requirements
  function automatic logic [DW:0] exp_out(int o);
    logic [DW:0] r = '0;
    if (!enable) return r;                                    // R7
    if (m_vld[bslot][o]) begin
      int s = int'(m_sel[bslot][o]);
      if (s < 5 && in_valid[s]) r = {1'b1, in_data[s*DW +: DW]}; // R3, R4
    end else if (o < 4 && be_valid && int'(be_dir) == o) begin
      r = {1'b1, be_data};                                    // R5
    end
    return r;                                                 // R9 zero data
  endfunction

  function automatic bit exp_ready();
    if (!enable || !be_valid || be_dir > 3'd3) return 1'b0;   // R6, R7
    return !m_vld[bslot][be_dir];
  endfunction

  task automatic compare_all(string tag);
    for (int o = 0; o < 5; o++)
      check({tag, " R3/R4/R5/R9 out"}, {out_valid[o], out_data[o*DW +: DW]}, exp_out(o));
    check({tag, " R5/R6 be_ready"}, {{DW{1'b0}}, be_ready}, {{DW{1'b0}}, exp_ready()});
  endtask

  task automatic drive_random(int vdens);
    for (int p = 0; p < 5; p++) begin
      in_valid[p] = ($urandom % 100) < vdens;
      in_data[p*DW +: DW] = rnd_word();
    end
    be_valid = $urandom % 2;
    be_dir   = 3'($urandom % 8);
    be_data  = rnd_word();
  endtask

  // at negedge: inputs set; check; advance through posedge to next negedge
  task automatic step(string tag);
    #1;
    compare_all(tag);
    @(posedge clk);
    if (enable) bslot = (bslot + 1) % P; else bslot = 0;      // R2 model
    @(negedge clk);
  endtask

  task automatic cfg_write(int s, int p, bit v, int sel);
    cfg_we = 1'b1; cfg_slot = SW'(s); cfg_port = 3'(p);
    cfg_valid = v; cfg_sel = 3'(sel);
    @(posedge clk);
    if (!enable) begin m_vld[s][p] = v; m_sel[s][p] = 3'(sel); end  // R8
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s < P; s++)
      for (int p = 0; p < 5; p++) begin m_vld[s][p] = 1'b0; m_sel[s][p] = '0; end
    rst_n = 1'b0; enable = 1'b0; cfg_we = 1'b0; cfg_slot = '0; cfg_port = '0;
    cfg_valid = 1'b0; cfg_sel = '0; in_valid = '0; in_data = '0;
    be_valid = 1'b0; be_dir = '0; be_data = '0;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset outputs
    check("R1 reset out_valid", {{DW-4{1'b0}}, out_valid}, '0);
    check("R1 reset be_ready", {{DW{1'b0}}, be_ready}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: empty table after reset lets best-effort through in every slot
    enable = 1'b1; bslot = 0;
    for (int c = 0; c < P; c++) begin
      in_valid = 5'h1f; in_data = {rnd_word(), rnd_word(), rnd_word(), rnd_word(), rnd_word()};
      be_valid = 1'b1; be_dir = 3'(c % 4); be_data = rnd_word();
      #1;
      check("R1 empty table be_ready", {{DW{1'b0}}, be_ready}, {{DW{1'b0}}, 1'b1});
      step("R1");
    end

    // R7/R2: disable, random inputs, outputs quiet
    enable = 1'b0;
    for (int c = 0; c < 4; c++) begin drive_random(80); step("R7 disabled"); end

    // R8: load a directed schedule while disabled, incl. dead selects 5..7
    for (int s = 0; s < P; s++)
      for (int p = 0; p < 5; p++) begin
        int r = $urandom % 10;
        if (r < 4)      cfg_write(s, p, 1'b0, 0);
        else if (r < 9) cfg_write(s, p, 1'b1, $urandom % 5);
        else            cfg_write(s, p, 1'b1, 5 + $urandom % 3);
      end
    cfg_write(0, 0, 1'b1, 1);   // slot 0: east feeds north
    cfg_write(1, 1, 1'b0, 0);   // slot 1: east output free

    // R2: first enabled cycle is slot 0: north output follows east input
    enable = 1'b1; bslot = 0;
    in_valid = 5'b00010; in_data = '0; in_data[1*DW +: DW] = rnd_word();
    be_valid = 1'b1; be_dir = 3'd0; be_data = rnd_word();
    #1;
    check("R2 slot0 north from east", {out_valid[0], out_data[0 +: DW]}, {1'b1, in_data[DW +: DW]});
    check("R6 reserved dir blocks be", {{DW{1'b0}}, be_ready}, '0);
    step("R2");
    // slot 1: east output free, be toward east accepted
    be_valid = 1'b1; be_dir = 3'd1; be_data = rnd_word(); in_valid = '0;
    #1;
    check("R5 be takes free east", {out_valid[1], out_data[DW +: DW]}, {1'b1, be_data});
    step("R5");

    // R2/R3/R4/R5/R6/R8: random traffic over many periods with locked writes
    for (int c = 0; c < 20*P; c++) begin
      drive_random(50);
      if ($urandom % 6 == 0) begin
        cfg_we = 1'b1; cfg_slot = SW'($urandom % P); cfg_port = 3'($urandom % 5);
        cfg_valid = $urandom % 2; cfg_sel = 3'($urandom % 8);
      end else cfg_we = 1'b0;
      step("R8 random");
    end
    cfg_we = 1'b0;

    // R4: reserved with idle input stays quiet even with be aimed at it
    enable = 1'b0; @(negedge clk); bslot = 0;
    cfg_write(0, 2, 1'b1, 3);
    cfg_write(0, 3, 1'b1, 6);
    enable = 1'b1;
    in_valid = 5'b00000; in_data = '0; be_valid = 1'b1; be_dir = 3'd2; be_data = rnd_word();
    #1;
    check("R4 idle input quiet", {out_valid[2], out_data[2*DW +: DW]}, '0);
    check("R4 idle input no be", {{DW{1'b0}}, be_ready}, '0);
    step("R4");
    // slot 1 then back; wrap to slot 0 and test dead select with valid inputs
    for (int c = 1; c < P; c++) begin drive_random(50); step("R2 wrap"); end
    in_valid = 5'h1f; be_valid = 1'b1; be_dir = 3'd3;
    #1;
    check("R4 dead select quiet", {out_valid[3], out_data[3*DW +: DW]}, '0);
    step("R4");

    // R6: be_dir local or illegal never accepted
    for (int c = 0; c < 2*P; c++) begin
      drive_random(50); be_valid = 1'b1; be_dir = 3'(4 + $urandom % 4);
      #1;
      check("R6 non-neighbour dir", {{DW{1'b0}}, be_ready}, '0);
      step("R6");
    end

    enable = 1'b0;
    drive_random(90);
    step("R7 final");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule